// File: doc/BRIEF.md
# Sine-Modulated Pulse-Width Generator

This block produces a one-bit stream whose duty cycle traces a sine wave. It is meant as a stimulus source for a bit-stream filter. A master tick enable moves a period counter forward. Each PWM period is `PERIOD_TICKS` ticks long, and its high time is taken from a sine table of `SAMPLES` entries. The table is computed at elaboration from a fixed-point series, so it holds no stored constants.

One table entry is consumed per period. The index steps forward at each period boundary and wraps after the last entry. With the default parameters, 128 periods of 128 ticks form a modulation cycle that repeats every 16384 ticks. A longer period gives finer pulse-width steps but, for a fixed tick rate, a slower sine. The block also drives an end-of-period strobe, which lets a consumer frame the stream.

Top module: `sine_pwm_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_out` and `period_end` are 0. After reset is released, the first period uses table index 0 and starts at tick position 0.
- R2: A period is exactly `PERIOD_TICKS` ticks. `period_end` is high only in a cycle where `tick` is high on the last tick of a period (position `PERIOD_TICKS-1`), and it is high in every such cycle.
- R3: In a cycle with `tick` low, nothing advances: `pwm_out` holds its value and `period_end` stays 0.
- R4: After the tick at position j of a period, `pwm_out` is 1 when j is less than the period's width W and 0 otherwise. The high part is one run at the start of the period, W ticks long, and W cannot change within a period.
- R5: The table index advances by one per period and wraps from `SAMPLES-1` to 0. The waveform therefore repeats every `PERIOD_TICKS*SAMPLES` ticks.
- R6: The width for index k is within one tick of PERIOD_TICKS/2 + round((PERIOD_TICKS/2)·sin(2πk/SAMPLES)). It is exact at the quarter points: k=0 gives half, k=SAMPLES/4 gives PERIOD_TICKS (high for the whole period), k=SAMPLES/2 gives half, and k=3·SAMPLES/4 gives 0 (never high).
- R7: For every k below SAMPLES/2, the widths at k and k+SAMPLES/2 add up to exactly PERIOD_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Master tick enable; one PWM time step per high cycle |
| pwm_out | output | 1 | Registered PWM bit stream |
| period_end | output | 1 | High for the cycle carrying the last tick of each period |

## Verification
The end-of-period strobe and the step to the next sine sample fall on the same tick. The new width must take effect at the very next tick, not one period late. The bench provokes this at every boundary of a full modulation cycle, including the index wrap and the transitions into and out of full-high and all-low periods. It judges each boundary by checking that the strobe appears on that tick and that the following period's high run has a contiguous length matching the sine reference. Idle gaps placed just before and after boundaries confirm that a boundary is crossed only by a tick.

// File: rtl/sine_pwm_gen.sv
module sine_pwm_gen #(
  parameter int unsigned PERIOD_TICKS = 128,
  parameter int unsigned SAMPLES      = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic pwm_out,
  output logic period_end
);
  localparam int CW   = $clog2(PERIOD_TICKS);
  localparam int IW   = $clog2(SAMPLES);
  localparam int WW   = $clog2(PERIOD_TICKS + 1);
  localparam int HALF = PERIOD_TICKS / 2;
  localparam longint SCALE = 64'sd1 << 30;
  localparam longint PI_Q  = 64'sd3373259426;

  function automatic int sine_width(input int k);
    int q;
    longint th, term, acc, amp;
    q = k % (SAMPLES / 2);
    if (q > SAMPLES / 4) q = SAMPLES / 2 - q;
    th   = (2 * PI_Q * longint'(q)) / longint'(SAMPLES);
    term = th;
    acc  = th;
    for (int n = 1; n <= 10; n++) begin
      term = -((((term * th) / SCALE) * th) / SCALE) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    amp = (acc * longint'(HALF) + SCALE / 2) / SCALE;
    return (k < SAMPLES / 2) ? HALF + int'(amp) : HALF - int'(amp);
  endfunction

  logic [WW-1:0] tab [SAMPLES];

  for (genvar k = 0; k < SAMPLES; k++) begin : g_tab
    localparam int W = sine_width(k);
    assign tab[k] = WW'(W);
  end

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          last;

  assign last       = (cnt == CW'(PERIOD_TICKS - 1));
  assign period_end = tick & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      idx     <= '0;
      pwm_out <= 1'b0;
    end else if (tick) begin
      pwm_out <= (WW'(cnt) < tab[idx]);
      cnt     <= last ? '0 : cnt + CW'(1);
      if (last) idx <= (idx == IW'(SAMPLES - 1)) ? '0 : idx + IW'(1);
    end
  end
endmodule

// File: rtl/sine_pwm_gen_chk.sv
module sine_pwm_gen_chk #(
  parameter int unsigned PERIOD_TICKS = 128,
  parameter int unsigned SAMPLES      = 128
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pwm_out,
  input logic period_end
);
  localparam int CW = $clog2(PERIOD_TICKS);
  logic [CW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (tick) pos <= (pos == CW'(PERIOD_TICKS - 1)) ? '0 : pos + CW'(1);
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!pwm_out && !period_end); // R1
  end

  AST_STROBE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos == CW'(PERIOD_TICKS - 1)) |-> period_end); // R2

  AST_STROBE_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (tick && pos == CW'(PERIOD_TICKS - 1))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out)); // R3

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> ($past(tick) && $past(pos) == '0)); // R4
endmodule

bind sine_pwm_gen sine_pwm_gen_chk #(
  .PERIOD_TICKS(PERIOD_TICKS),
  .SAMPLES(SAMPLES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tick(tick),
  .pwm_out(pwm_out),
  .period_end(period_end)
);

// File: tb/tb_sine_pwm_gen.sv
`timescale 1ns/1ps
module tb_sine_pwm_gen;
  localparam int PER  = 128;
  localparam int N    = 128;
  localparam int HALF = PER / 2;

  logic clk = 1'b0;
  logic rst_n;
  logic tick = 1'b0;
  logic pwm_out, period_end;

  int checks = 0, errors = 0;
  int j = 0, k = 0, hi = 0, periods = 0;
  bit seen_low = 0;
  int meas [N];

  always #5 clk = ~clk;

  sine_pwm_gen #(.PERIOD_TICKS(PER), .SAMPLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pwm_out(pwm_out), .period_end(period_end));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (period %0d pos %0d)", req, act, exp, periods, j);
    end
  endtask

  function automatic int ref_w(input int idx);
    real r;
    r = HALF + HALF * $sin(2.0 * 3.14159265358979 * idx / N);
    return int'($floor(r + 0.5));
  endfunction

  task automatic close_period();
    int e, d;
    if (periods < N) begin
      meas[k] = hi;
      e = ref_w(k);
      d = hi - e;
      chk(d >= -1 && d <= 1, "R6 width", hi, e);
      if (k == 0 || k == N / 2) chk(hi == HALF, "R6 half point", hi, HALF);
      if (k == N / 4)           chk(hi == PER,  "R6 full high", hi, PER);
      if (k == 3 * N / 4)       chk(hi == 0,    "R6 never high", hi, 0);
    end else begin
      chk(hi == meas[k], "R5 repeat after wrap", hi, meas[k]);
    end
    periods++;
    j = 0; hi = 0; seen_low = 0;
    k = (k + 1) % N;
  endtask

  task automatic step(input bit t);
    logic prev;
    @(negedge clk);
    tick = t;
    #1;
    chk(period_end === (t && j == PER - 1), "R2 strobe", int'(period_end), int'(t && j == PER - 1));
    if (!t) chk(period_end === 1'b0, "R3 idle strobe", int'(period_end), 0);
    prev = pwm_out;
    @(posedge clk);
    #1;
    if (!t) begin
      chk(pwm_out === prev, "R3 idle hold", int'(pwm_out), int'(prev));
    end else begin
      if (pwm_out === 1'b1) begin
        chk(!seen_low, "R4 contiguous high", 1, 0);
        hi++;
      end else begin
        seen_low = 1;
      end
      if (j == PER - 1) close_period();
      else j++;
    end
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick  = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(pwm_out === 1'b0 && period_end === 1'b0, "R1 reset quiet", int'(pwm_out), 0);
    end
    @(negedge clk);
    tick  = 1'b0;
    rst_n = 1'b1;

    // one full modulation cycle plus one period past the wrap, with idle gaps
    for (int n = 0; n < PER * N + PER; n++) begin
      step(1'b1);
      if (n % 509 == 126 || n % 509 == 127) begin
        step(1'b0); step(1'b0);
      end
    end
    for (int i = 0; i < N / 2; i++)
      chk(meas[i] + meas[i + N / 2] == PER, "R7 symmetry", meas[i] + meas[i + N / 2], PER);

    // partial period with sparse ticks, then reset mid-period
    for (int n = 0; n < PER / 3; n++) begin
      step(1'b1); step(1'b0);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pwm_out === 1'b0, "R1 reset mid-run", int'(pwm_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    j = 0; hi = 0; seen_low = 0; k = 0; periods = N;
    for (int n = 0; n < 2 * PER; n++) step(1'b1);
    chk(k == 2, "R1 restart at index 0", k, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule